// File: doc/BRIEF.md
# Banked Extended Register Access

This block sits between a host register port and a serial channel. It decodes a single register address that can reach two different registers: the ordinary sync-character register and an extended feature register. Which of the two a write reaches depends on a bank-select bit in the channel's master control register. The host first loads a register pointer, then makes one write or read access through it. After that access the pointer falls back to zero.

The extended feature register cannot be read back at its own address. It shows up at the status read address 14 only if the value last written to it had its readback-enable bit set. Otherwise address 14, like every other address, returns the status the channel supplies for the current pointer. The feature bits stay in force until software writes them again, a software reset is issued, or the hardware reset is asserted.

Top module: `banked_reg_access`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `syncReg`, `extReg`, `bankSel`, `curPtr` and `rdValid` all become 0.
- R2: With `bankSel` = 0, a write at pointer 7 loads `wrData` into `syncReg` at the next edge and leaves `extReg` unchanged.
- R3: With `bankSel` = 1, a write at pointer 7 loads `wrData` into `extReg` at the next edge and leaves `syncReg` unchanged.
- R4: A write at pointer 15 stores the control byte; its bit 0 drives `bankSel` from the next edge on.
- R5: A read at pointer 14 while `extReg` bit 6 is 1 returns `extReg` on `rdData`, with `rdValid` high for exactly the cycle after `rdEn`.
- R6: A read at pointer 14 while `extReg` bit 6 is 0, or a read at any other pointer, returns `chanStatus` as sampled in the `rdEn` cycle.
- R7: `ptrWr` loads `ptrVal` into `curPtr`; any write or read access returns `curPtr` to 0 at the next edge.
- R8: A `swReset` cycle clears `extReg` and `curPtr`, leaves `syncReg` and `bankSel` unchanged, and cancels any write or read in the same cycle.
- R9: `extReg` keeps its value across bank-select changes, sync writes and reads until it is rewritten or reset.
- R10: When `wrEn` and `rdEn` are both high, the write is performed and the read is dropped: `rdValid` stays 0.
- R11: Writes at pointers other than 7 and 15 change none of `syncReg`, `extReg` and `bankSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| swReset | input | 1 | Software reset strobe |
| ptrWr | input | 1 | Load the register pointer |
| ptrVal | input | 4 | Pointer value to load |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| wrData | input | 8 | Write data |
| chanStatus | input | 8 | Channel status for the current pointer |
| curPtr | output | 4 | Current register pointer |
| syncReg | output | 8 | Sync-character register |
| extReg | output | 8 | Extended feature register |
| bankSel | output | 1 | Bank-select bit of the control register |
| rdData | output | 8 | Read data, held until the next read |
| rdValid | output | 1 | One-cycle pulse marking a completed read |

## Verification
A wrong bank-select bit sends the next write at pointer 7 to the other register. This shows one cycle later as a `syncReg` or `extReg` that failed to change, or that changed when it should not have. A stale readback-enable bit or a stuck pointer shows on the first read of address 14, or on the first access that should land at pointer 0: `rdData` holds the wrong byte in the cycle after `rdEn`. A bad clear on software or hardware reset shows on `extReg` one edge after the strobe.

// File: rtl/banked_reg_pkg.sv
package banked_reg_pkg;

  localparam int DATA_W = 8;
  localparam int PTR_W  = 4;

  typedef struct packed {
    logic wrSync;
    logic wrExt;
    logic wrCtrl;
    logic rdExt;
    logic rdStat;
    logic clrExt;
  } regStb_t;

endpackage

// File: rtl/banked_reg_ctrl.sv
module banked_reg_ctrl
  import banked_reg_pkg::*;
#(
  parameter int PW        = PTR_W,
  parameter int SYNC_ADDR = 7,
  parameter int CTRL_ADDR = 15,
  parameter int RDBK_ADDR = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swReset,
  input  logic          ptrWr,
  input  logic [PW-1:0] ptrVal,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          bankBit,
  input  logic          rdbkBit,
  output logic [PW-1:0] ptrQ,
  output regStb_t       stb
);

  localparam logic [PW-1:0] SyncPtr = PW'(SYNC_ADDR);
  localparam logic [PW-1:0] CtrlPtr = PW'(CTRL_ADDR);
  localparam logic [PW-1:0] RdbkPtr = PW'(RDBK_ADDR);

  logic wrGo;
  logic rdGo;
  logic atSync;
  logic atCtrl;
  logic atRdbk;

  // Software reset cancels all accesses; a write beats a read.
  assign wrGo   = wrEn && !swReset;
  assign rdGo   = rdEn && !wrEn && !swReset;
  assign atSync = (ptrQ == SyncPtr);
  assign atCtrl = (ptrQ == CtrlPtr);
  assign atRdbk = (ptrQ == RdbkPtr);

  always_comb begin
    stb        = '0;
    stb.wrSync = wrGo && atSync && !bankBit;
    stb.wrExt  = wrGo && atSync && bankBit;
    stb.wrCtrl = wrGo && atCtrl;
    stb.rdExt  = rdGo && atRdbk && rdbkBit;
    stb.rdStat = rdGo && !(atRdbk && rdbkBit);
    stb.clrExt = swReset;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptrQ <= '0;
    end else if (swReset || wrEn || rdEn) begin
      ptrQ <= '0;
    end else if (ptrWr) begin
      ptrQ <= ptrVal;
    end
  end

  // R7: the pointer is back at zero after every access
  p_ptr_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn || rdEn) |=> (ptrQ == '0));

  // R10: a simultaneous write suppresses the read
  p_wr_beats_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && rdEn) |-> !(stb.rdExt || stb.rdStat));

  // R2 / R3: at most one register write per cycle
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.wrSync, stb.wrExt, stb.wrCtrl}));

endmodule

// File: rtl/banked_reg_data.sv
module banked_reg_data
  import banked_reg_pkg::*;
#(
  parameter int DW       = DATA_W,
  parameter int BANK_BIT = 0,
  parameter int RDBK_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  regStb_t       stb,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] chanStatus,
  output logic [DW-1:0] syncQ,
  output logic [DW-1:0] extQ,
  output logic [DW-1:0] ctrlQ,
  output logic [DW-1:0] rdQ,
  output logic          rdValidQ
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncQ <= '0;
    end else if (stb.wrSync) begin
      syncQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlQ <= '0;
    end else if (stb.wrCtrl) begin
      ctrlQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stb.clrExt) begin
      extQ <= '0;
    end else if (stb.wrExt) begin
      extQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdQ      <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= stb.rdExt || stb.rdStat;
      if (stb.rdExt) begin
        rdQ <= extQ;
      end else if (stb.rdStat) begin
        rdQ <= chanStatus;
      end
    end
  end

  // R3: sync register untouched unless a sync write is decoded
  p_sync_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.wrSync |=> $stable(syncQ));

  // R9: feature bits persist until rewritten or cleared
  p_ext_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.wrExt && !stb.clrExt) |=> $stable(extQ));

  // R8: software reset leaves the feature register empty
  p_sw_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clrExt |=> (extQ == '0));

  // R5: readback path delivers the feature register
  p_rdbk_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rdExt |=> (rdValidQ && rdQ == $past(extQ)));

  // R4: control byte only moves on a control write
  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.wrCtrl |=> $stable(ctrlQ[BANK_BIT]));

  // R5: readback enable bit position is inside the word
  initial begin
    assert (RDBK_BIT < DW && BANK_BIT < DW)
      else $error("bit positions out of range");
  end

endmodule

// File: rtl/banked_reg_access.sv
module banked_reg_access
  import banked_reg_pkg::*;
#(
  parameter int DW        = DATA_W,
  parameter int PW        = PTR_W,
  parameter int SYNC_ADDR = 7,
  parameter int CTRL_ADDR = 15,
  parameter int RDBK_ADDR = 14,
  parameter int BANK_BIT  = 0,
  parameter int RDBK_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swReset,
  input  logic          ptrWr,
  input  logic [PW-1:0] ptrVal,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] chanStatus,
  output logic [PW-1:0] curPtr,
  output logic [DW-1:0] syncReg,
  output logic [DW-1:0] extReg,
  output logic          bankSel,
  output logic [DW-1:0] rdData,
  output logic          rdValid
);

  regStb_t       stb;
  logic [DW-1:0] ctrlQ;

  assign bankSel = ctrlQ[BANK_BIT];

  banked_reg_ctrl #(
    .PW(PW), .SYNC_ADDR(SYNC_ADDR), .CTRL_ADDR(CTRL_ADDR), .RDBK_ADDR(RDBK_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .swReset(swReset), .ptrWr(ptrWr), .ptrVal(ptrVal),
    .wrEn(wrEn), .rdEn(rdEn), .bankBit(ctrlQ[BANK_BIT]), .rdbkBit(extReg[RDBK_BIT]),
    .ptrQ(curPtr), .stb(stb)
  );

  banked_reg_data #(
    .DW(DW), .BANK_BIT(BANK_BIT), .RDBK_BIT(RDBK_BIT)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(wrData), .chanStatus(chanStatus),
    .syncQ(syncReg), .extQ(extReg), .ctrlQ(ctrlQ), .rdQ(rdData), .rdValidQ(rdValid)
  );

endmodule

// File: tb/banked_reg_access_test.sv
module banked_reg_access_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       swReset = 1'b0;
  logic       ptrWr = 1'b0;
  logic [3:0] ptrVal = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] chanStatus = '0;
  logic [3:0] curPtr;
  logic [7:0] syncReg;
  logic [7:0] extReg;
  logic       bankSel;
  logic [7:0] rdData;
  logic       rdValid;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] mSync;
  logic [7:0] mExt;
  logic       mBank;

  always #4 clk = ~clk;

  banked_reg_access uut (
    .clk(clk), .rst_n(rst_n), .swReset(swReset), .ptrWr(ptrWr), .ptrVal(ptrVal),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .chanStatus(chanStatus),
    .curPtr(curPtr), .syncReg(syncReg), .extReg(extReg), .bankSel(bankSel),
    .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    check(req, syncReg, mSync);
    check(req, extReg, mExt);
    check(req, {7'd0, bankSel}, {7'd0, mBank});
  endtask

  task automatic loadPtr(input logic [3:0] a);
    @(negedge clk);
    ptrWr = 1'b1; ptrVal = a;
    @(negedge clk);
    ptrWr = 1'b0;
    check("R7 pointer load", {4'd0, curPtr}, {4'd0, a});
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    loadPtr(a);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 4'd7 && !mBank) mSync = d;
    if (a == 4'd7 && mBank) mExt = d;
    if (a == 4'd15) mBank = d[0];
    check("R7 pointer home after write", {4'd0, curPtr}, 8'd0);
  endtask

  task automatic regRead(input logic [3:0] a, input logic [7:0] st, output logic [7:0] got);
    loadPtr(a);
    rdEn = 1'b1; chanStatus = st;
    @(negedge clk);
    rdEn = 1'b0;
    got = rdData;
    check("R5 rdValid pulse", {7'd0, rdValid}, 8'd1);
    @(negedge clk);
    check("R5 rdValid single cycle", {7'd0, rdValid}, 8'd0);
  endtask

  initial begin
    logic [7:0] got;
    logic [7:0] expv;
    mSync = '0; mExt = '0; mBank = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset sync", syncReg, 8'd0);
    check("R1 reset ext", extReg, 8'd0);
    check("R1 reset ptr/valid", {curPtr, 3'd0, rdValid}, 8'd0);
    rst_n = 1'b1;

    // R2 / R3 / R11 sweep: every pointer under both banks
    for (int b = 0; b < 2; b++) begin
      regWrite(4'd15, 8'(b) | 8'h40);
      checkState("R4 bank select");
      for (int a = 0; a < 16; a++) begin
        if (a == 15) continue;
        regWrite(4'(a), 8'((a * 29 + b * 101 + 7) & 255));
        checkState(a == 7 ? (b == 1 ? "R3 ext write" : "R2 sync write") : "R11 other write");
      end
    end

    // R5 / R6 sweep: every read pointer, readback on and off
    for (int e = 0; e < 2; e++) begin
      regWrite(4'd15, 8'd1);
      regWrite(4'd7, e ? 8'h5C : 8'h1C);
      regWrite(4'd15, 8'd0);
      for (int a = 0; a < 16; a++) begin
        logic [7:0] st;
        st = 8'((a * 17) ^ 8'hA5);
        regRead(4'(a), st, got);
        expv = (a == 14 && mExt[6]) ? mExt : st;
        check(expv == mExt && a == 14 ? "R5 readback" : "R6 status read", got, expv);
      end
    end

    // R9: ext persists across bank toggles and sync writes
    regWrite(4'd15, 8'd1);
    regWrite(4'd7, 8'h4B);
    regWrite(4'd15, 8'd0);
    regWrite(4'd7, 8'h33);
    regRead(4'd3, 8'h00, got);
    checkState("R9 ext persists");

    // R10: write and read together
    loadPtr(4'd7);
    wrEn = 1'b1; rdEn = 1'b1; wrData = 8'h77;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    mSync = 8'h77;
    check("R10 no rdValid", {7'd0, rdValid}, 8'd0);
    checkState("R10 write done");

    // R8: software reset, with a cancelled ext write
    regWrite(4'd15, 8'd1);
    loadPtr(4'd7);
    swReset = 1'b1; wrEn = 1'b1; wrData = 8'hEE;
    @(negedge clk);
    swReset = 1'b0; wrEn = 1'b0;
    mExt = 8'h00;
    checkState("R8 sw reset");
    check("R8 pointer cleared", {4'd0, curPtr}, 8'd0);
    regWrite(4'd7, 8'h42);
    checkState("R8 ext writable after");

    // R1: hardware reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mSync = 0; mExt = 0; mBank = 0;
    checkState("R1 hw reset");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule